// File: doc/BRIEF.md
# Speculative Load Address Table

This block tracks loads that a compiler has hoisted above stores whose addresses it could not prove distinct. When such an early load executes, it records its destination register, its byte address and its access width in a small fully associative table. Every store that follows is snooped against the table. Any recorded load whose byte range overlaps the store's byte range is dropped, because the value it fetched may now be stale.

Later, a check operation names a destination register. If that register still has an entry, the early load is known to be good. If not, recovery is needed. Each cycle can carry one insert, one store snoop and one check. Each check returns its verdict on the cycle after it is presented. The memory access and the recovery path sit outside this block.

Top module: `spec_addr_table`

## Requirements
- R1: After reset the table holds no entries and `chk_done` and `chk_hit` are low, so any check returns a miss.
- R2: A check presented on `chk_valid` raises `chk_done` on the next cycle, together with its verdict on `chk_hit`. `chk_done` is low in every cycle that follows a cycle without a check, and `chk_hit` is never high while `chk_done` is low.
- R3: After an insert for a register, a check for that register reports a hit (`chk_hit` = 1).
- R4: A check for a register that has no entry reports a miss (`chk_done` = 1, `chk_hit` = 0), which signals that recovery is required.
- R5: A store invalidates every entry whose byte range [addr, addr+len) overlaps the store's byte range. A store leaves non-overlapping entries, including adjacent ones, untouched. The size code gives len: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R6: The table holds at most one entry per register. A new insert for a register that already has an entry replaces that entry's address and size.
- R7: When an insert and an overlapping store arrive in the same cycle, the store is applied first, so the newly inserted entry survives.
- R8: A check with `chk_clear` = 0 leaves the entry in place. A check with `chk_clear` = 1 removes it after reporting. When an insert and a clearing check name the same register in the same cycle, the insert's entry remains.
- R9: An insert for a register that has no entry takes the lowest-numbered free slot. When no slot is free, it replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping at the table depth, only on such a replacement.
- R10: A check reports the table as it stood at the start of its cycle. A store, clear or insert in the same cycle does not change that check's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Record an early load this cycle |
| ins_reg | input | REG_W | Destination register of the early load |
| ins_addr | input | ADDR_W | Byte address of the early load |
| ins_size | input | 2 | Size code of the early load |
| st_valid | input | 1 | Snoop a store this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Size code of the store |
| chk_valid | input | 1 | Check a register this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_clear | input | 1 | Remove the checked entry after reporting |
| chk_done | output | 1 | A check verdict is present |
| chk_hit | output | 1 | Verdict: 1 = speculation held, 0 = recovery needed |

## Verification
The assertions check the check-response timing on every cycle, the rule of one entry per register, and the rule that a freshly inserted register is present in the next cycle, even when an overlapping store arrives with it. The overlap arithmetic for stores, including adjacency and straddling cases, cannot be seen in any single cycle. The same holds for replacement order when the table is full, for clear-versus-insert ordering, and for the view a check has of the table before same-cycle updates. Only the bench's directed scenarios and its randomised run against a behavioural model show these.

// File: rtl/sat_pkg.sv
package sat_pkg;

    // Length in bytes for a two-bit size code.
    function automatic logic [64:0] span_bytes(input logic [1:0] code);
        return 65'd1 << code;
    endfunction

    // True when the half-open byte ranges of two accesses intersect.
    function automatic logic bytes_overlap(input logic [63:0] a_base, input logic [1:0] a_code,
                                           input logic [63:0] b_base, input logic [1:0] b_code);
        logic [64:0] a_lo, a_hi, b_lo, b_hi;
        a_lo = {1'b0, a_base};
        b_lo = {1'b0, b_base};
        a_hi = a_lo + span_bytes(a_code);
        b_hi = b_lo + span_bytes(b_code);
        return (a_lo < b_hi) && (b_lo < a_hi);
    endfunction

endpackage

// File: rtl/sat_match.sv
module sat_match #(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 32
) (
    input  logic [ENTRIES-1:0]        vld,
    input  logic [ENTRIES*REG_W-1:0]  regs,
    input  logic [ENTRIES*ADDR_W-1:0] addrs,
    input  logic [2*ENTRIES-1:0]      sizes,
    input  logic [ADDR_W-1:0]         st_addr,
    input  logic [1:0]                st_size,
    input  logic [REG_W-1:0]          chk_reg,
    input  logic [REG_W-1:0]          ins_reg,
    output logic [ENTRIES-1:0]        st_kill,
    output logic [ENTRIES-1:0]        chk_sel,
    output logic [ENTRIES-1:0]        ins_regeq
);
    import sat_pkg::*;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic [REG_W-1:0]  slot_reg;
        logic [ADDR_W-1:0] slot_addr;
        assign slot_reg   = regs[i*REG_W +: REG_W];
        assign slot_addr  = addrs[i*ADDR_W +: ADDR_W];
        assign st_kill[i] = vld[i] & bytes_overlap(64'(slot_addr), sizes[2*i +: 2],
                                                   64'(st_addr), st_size);
        assign chk_sel[i]   = vld[i] & (slot_reg == chk_reg);
        assign ins_regeq[i] = (slot_reg == ins_reg);
    end
endmodule

// File: rtl/sat_victim.sv
module sat_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic [ENTRIES-1:0] same,
    input  logic [ENTRIES-1:0] free,
    input  logic [IDX_W-1:0]   rr,
    output logic [IDX_W-1:0]   slot,
    output logic               use_rr
);
    logic [IDX_W-1:0] same_idx, free_idx;

    always_comb begin
        same_idx = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (same[i]) same_idx = IDX_W'(i);
            if (free[i]) free_idx = IDX_W'(i);
        end
        use_rr = 1'b0;
        if (|same)      slot = same_idx;
        else if (|free) slot = free_idx;
        else begin
            slot   = rr;
            use_rr = 1'b1;
        end
    end
endmodule

// File: rtl/spec_addr_table.sv
module spec_addr_table #(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [REG_W-1:0]  ins_reg,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [1:0]        ins_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_clear,
    output logic              chk_done,
    output logic              chk_hit
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]        vld;
        logic [ENTRIES*REG_W-1:0]  regs;
        logic [ENTRIES*ADDR_W-1:0] addrs;
        logic [2*ENTRIES-1:0]      sizes;
        logic [IDX_W-1:0]          rr;
        logic                      done;
        logic                      hit;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] st_kill, chk_sel, ins_regeq;
    logic [ENTRIES-1:0] vld_mid;
    logic [IDX_W-1:0]   slot;
    logic               use_rr;
    logic [ENTRIES-1:0] tbl_vld;
    logic [ENTRIES*REG_W-1:0] tbl_regs;

    sat_match #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_match (
        .vld       (s_q.vld),
        .regs      (s_q.regs),
        .addrs     (s_q.addrs),
        .sizes     (s_q.sizes),
        .st_addr   (st_addr),
        .st_size   (st_size),
        .chk_reg   (chk_reg),
        .ins_reg   (ins_reg),
        .st_kill   (st_kill),
        .chk_sel   (chk_sel),
        .ins_regeq (ins_regeq)
    );

    // Table occupancy after this cycle's store and clear, before the insert.
    always_comb begin
        vld_mid = s_q.vld;
        if (st_valid)               vld_mid = vld_mid & ~st_kill;
        if (chk_valid && chk_clear) vld_mid = vld_mid & ~chk_sel;
    end

    sat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .same   (ins_regeq & vld_mid),
        .free   (~vld_mid),
        .rr     (s_q.rr),
        .slot   (slot),
        .use_rr (use_rr)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = chk_valid;
        s_d.hit  = chk_valid & (|chk_sel);
        s_d.vld  = vld_mid;
        if (ins_valid) begin
            s_d.vld[slot]                       = 1'b1;
            s_d.regs[slot*REG_W +: REG_W]       = ins_reg;
            s_d.addrs[slot*ADDR_W +: ADDR_W]    = ins_addr;
            s_d.sizes[slot*2 +: 2]              = ins_size;
            if (use_rr) begin
                s_d.rr = (s_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : s_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign chk_done = s_q.done;
    assign chk_hit  = s_q.hit;
    assign tbl_vld  = s_q.vld;
    assign tbl_regs = s_q.regs;
endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ins_valid,
    input logic [REG_W-1:0]         ins_reg,
    input logic                     chk_valid,
    input logic                     chk_done,
    input logic                     chk_hit,
    input logic [ENTRIES-1:0]       tbl_vld,
    input logic [ENTRIES*REG_W-1:0] tbl_regs
);
    logic             dup;
    logic             last_ins_v;
    logic [REG_W-1:0] last_ins_reg;
    logic             last_present;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ins_v   <= 1'b0;
            last_ins_reg <= '0;
        end else begin
            last_ins_v   <= ins_valid;
            last_ins_reg <= ins_reg;
        end
    end

    always_comb begin
        dup          = 1'b0;
        last_present = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (tbl_vld[i] && tbl_regs[i*REG_W +: REG_W] == last_ins_reg) last_present = 1'b1;
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (tbl_vld[i] && tbl_vld[j] &&
                    tbl_regs[i*REG_W +: REG_W] == tbl_regs[j*REG_W +: REG_W]) dup = 1'b1;
            end
        end
    end

    p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_done);
    p_hit_needs_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hit |-> chk_done);
    p_one_entry_per_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dup);
    p_insert_survives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_ins_v |-> last_present);
endmodule

bind spec_addr_table sat_checker #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_reg   (ins_reg),
    .chk_valid (chk_valid),
    .chk_done  (chk_done),
    .chk_hit   (chk_hit),
    .tbl_vld   (tbl_vld),
    .tbl_regs  (tbl_regs)
);

// File: tb/spec_addr_table_tb.sv
module spec_addr_table_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0, chk_clear = 1'b0;
    logic [6:0]  ins_reg = '0, chk_reg = '0;
    logic [31:0] ins_addr = '0, st_addr = '0;
    logic [1:0]  ins_size = '0, st_size = '0;
    logic        chk_done, chk_hit;

    int checks = 0, failures = 0;
    bit finished = 0;

    // Behavioural reference model
    bit     m_v[N];
    int     m_r[N];
    longint m_a[N];
    int     m_s[N];
    int     m_rr;
    bit     exp_done, exp_hit;

    spec_addr_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_reg(ins_reg), .ins_addr(ins_addr), .ins_size(ins_size),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_clear(chk_clear),
        .chk_done(chk_done), .chk_hit(chk_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit ranges_meet(longint a, int asz, longint b, int bsz);
        return (a < b + (longint'(1) << bsz)) && (b < a + (longint'(1) << asz));
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_rr = 0;
        exp_done = 0;
        exp_hit = 0;
    endtask

    task automatic compare(string tag);
        checks++;
        if (chk_done !== exp_done || chk_hit !== exp_hit) begin
            failures++;
            $display("FAIL %s done/hit=%0b/%0b expected %0b/%0b at %0t",
                     tag, chk_done, chk_hit, exp_done, exp_hit, $time);
        end
    endtask

    // One clock: drive inputs, advance model, compare at the following falling edge.
    task automatic step(bit iv, int ir, longint ia, int isz,
                        bit sv, longint sa, int ssz,
                        bit cv, int cr, bit cc, string tag);
        int slot;
        ins_valid = iv; ins_reg = 7'(ir); ins_addr = 32'(ia); ins_size = 2'(isz);
        st_valid = sv; st_addr = 32'(sa); st_size = 2'(ssz);
        chk_valid = cv; chk_reg = 7'(cr); chk_clear = cc;
        exp_done = cv;
        exp_hit = 0;
        for (int i = 0; i < N; i++) if (cv && m_v[i] && m_r[i] == cr) exp_hit = 1;
        if (sv) for (int i = 0; i < N; i++)
            if (m_v[i] && ranges_meet(m_a[i], m_s[i], sa, ssz)) m_v[i] = 0;
        if (cv && cc) for (int i = 0; i < N; i++) if (m_v[i] && m_r[i] == cr) m_v[i] = 0;
        if (iv) begin
            slot = -1;
            for (int i = 0; i < N; i++) if (slot < 0 && m_v[i] && m_r[i] == ir) slot = i;
            for (int i = 0; i < N; i++) if (slot < 0 && !m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[slot] = 1; m_r[slot] = ir; m_a[slot] = ia; m_s[slot] = isz;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic chk(int r, bit clr, string tag);
        step(0, 0, 0, 0, 0, 0, 0, 1, r, clr, tag);
    endtask
    task automatic ins(int r, longint a, int sz, string tag);
        step(1, r, a, sz, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic sto(longint a, int sz, string tag);
        step(0, 0, 0, 0, 1, a, sz, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        ins_valid = 0; st_valid = 0; chk_valid = 0; chk_clear = 0;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1;
        compare("R1 reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired R2 done/hit=%0b/%0b expected finish", chk_done, chk_hit);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk(5, 0, "R1 empty table misses");
        // R3 / R2
        ins(5, 'h100, 3, "R2 no check no done");
        chk(5, 0, "R3 hit after insert");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");
        chk(9, 0, "R4 absent register misses");
        // R5 overlap rules, entry 0x100..0x107
        sto('h108, 2, "R5 adjacent above");
        chk(5, 0, "R5 adjacent above keeps");
        sto('h0FE, 1, "R5 adjacent below");
        chk(5, 0, "R5 adjacent below keeps");
        sto('h107, 0, "R5 last byte");
        chk(5, 0, "R5 last byte kills");
        ins(6, 'h100, 0, "R5 insert");
        sto('h0FE, 2, "R5 straddle");
        chk(6, 0, "R5 straddle kills");
        // R6 replacement
        ins(7, 'h200, 2, "R6 first");
        ins(7, 'h300, 2, "R6 second");
        sto('h200, 2, "R6 old address store");
        chk(7, 0, "R6 new address kept");
        sto('h302, 0, "R6 new address store");
        chk(7, 0, "R6 new address killed");
        // R7 same-cycle insert and store
        step(1, 8, 'h400, 3, 1, 'h404, 0, 0, 0, 0, "R7 insert with store");
        chk(8, 0, "R7 insert survives");
        // R8 clear variants
        chk(8, 0, "R8 plain check");
        chk(8, 1, "R8 clearing check hits");
        chk(8, 0, "R8 cleared entry misses");
        ins(8, 'h440, 1, "R8 reinsert");
        step(1, 8, 'h480, 0, 0, 0, 0, 1, 8, 1, "R8 clear with insert");
        chk(8, 0, "R8 insert beats clear");
        // R10 check sees start-of-cycle state
        step(0, 0, 0, 0, 1, 'h480, 0, 1, 8, 0, "R10 check with store");
        chk(8, 0, "R10 store applied after");
        ins(11, 'h500, 0, "R10 setup");
        step(1, 12, 'h600, 0, 0, 0, 0, 1, 12, 0, "R10 check with insert");
        // R9 replacement order
        do_reset();
        for (int i = 0; i < N; i++) ins(i, 'h1000 + 16 * i, 3, "R9 fill");
        ins(20, 'h2000, 3, "R9 replace");
        chk(0, 0, "R9 slot0 replaced");
        chk(1, 0, "R9 slot1 kept");
        chk(20, 0, "R9 new present");
        ins(21, 'h2100, 3, "R9 replace next");
        chk(1, 0, "R9 slot1 replaced");
        chk(5, 1, "R9 free slot5");
        ins(22, 'h2200, 3, "R9 free slot used");
        chk(2, 0, "R9 pointer not moved");
        chk(22, 0, "R9 inserted");
        // Randomised run against the model
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 1), $urandom_range(0, 9), 'h40 + $urandom_range(0, 63), $urandom_range(0, 3),
                 $urandom_range(0, 2) == 0, 'h40 + $urandom_range(0, 63), $urandom_range(0, 3),
                 $urandom_range(0, 1), $urandom_range(0, 9), $urandom_range(0, 3) == 0,
                 "R5 R6 R9 random");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule